// File: doc/BRIEF.md
# Resolver Angle and Velocity Sample Reader

This block takes one reading from a resolver-to-digital converter on request. It freezes the converter's output by pulling the active-low sample strobe low, then waits a programmable setup time. It drives the two data-select pins so that either the angle register or the angular-velocity register is presented. It then clocks in a 16-bit word over an SPI link that idles high and samples on rising edges, most significant bit first. When the frame closes, the sample strobe is released and the raw word is scaled to the configured resolution. The result appears on a 16-bit output together with a one-cycle valid strobe.

Four resolutions are supported, chosen by a 2-bit code. A velocity reading is right-justified and sign-extended from its top valid bit. An angle reading is right-justified only when hysteresis is enabled; otherwise the whole 16-bit word is passed through. After each read a programmable hold time passes before a new request can be taken. Setup time, hold time and the SPI half period are parameters, all counted in system clock cycles.

Top module: `rsv_sample_reader`

## Requirements
- R1: At reset and while idle: `sample_n_o`, `spi_cs_n_o` and `spi_sck_o` are 1, `busy_o` and `valid_o` are 0, and `value_o` and `mode_o` are 0.
- R2: A request is taken at a rising clock edge where `req_i` is 1 and `busy_o` is 0. From the next cycle on, `sample_n_o` is 0 and `busy_o` is 1. `sample_n_o` stays low for exactly SETUP_CYC cycles before `spi_cs_n_o` falls.
- R3: `mode_o` is {A1,A0}. It becomes 2'b10 for a velocity request (`chan_i`=1) and 2'b00 for an angle request (`chan_i`=0). It is set in the first cycle after acceptance and held until the next acceptance.
- R4: A frame holds `spi_cs_n_o` low for 32*SCK_HALF cycles. `spi_sck_o` starts low and alternates low and high, each phase lasting SCK_HALF cycles, which gives 16 rising edges. `spi_miso_i` is sampled at each rising edge, and the first bit is the word's bit 15. `spi_sck_o` is 1 whenever `spi_cs_n_o` is 1.
- R5: Resolution codes 0, 1, 2 and 3 mean 10, 12, 14 and 16 bits. A velocity result is the word shifted right by 16 minus the resolution, with bit (resolution-1) copied into all higher bits.
- R6: An angle result with `hyst_en_i`=1 is the word shifted right logically by 16 minus the resolution. With `hyst_en_i`=0 it is the word unchanged.
- R7: `valid_o` is high for exactly one cycle: the first cycle after `spi_cs_n_o` rises. In that same cycle `sample_n_o` returns to 1 and `value_o` takes the new result. `value_o` does not change in any other cycle.
- R8: `busy_o` stays 1 for HOLD_CYC cycles, starting with the valid cycle, and then drops. A request made while `busy_o` is 1 is ignored.
- R9: Channel, resolution code and hysteresis enable are captured when the request is taken. Changing them during a read does not alter that read's result or its pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request one reading |
| chan_i | input | 1 | 0 = angle, 1 = angular velocity |
| res_code_i | input | 2 | Resolution code (10/12/14/16 bits) |
| hyst_en_i | input | 1 | Hysteresis enable; selects angle justification |
| busy_o | output | 1 | Read or hold in progress |
| sample_n_o | output | 1 | Active-low sample strobe to the converter |
| mode_o | output | 2 | Data-select pins {A1,A0} |
| spi_sck_o | output | 1 | SPI clock, idles high |
| spi_cs_n_o | output | 1 | SPI chip select, active low |
| spi_miso_i | input | 1 | SPI data from the converter |
| value_o | output | 16 | Scaled reading |
| valid_o | output | 1 | One-cycle strobe marking a new reading |

## Verification
The bench checks every resolution code for both channels, with hysteresis on and off, using words whose top valid bit is set. A design that sign-extended from the wrong bit, or that shifted angles while hysteresis was off, would show the wrong upper bits. Some reads change channel, resolution and hysteresis partway through. A design that failed to capture them at acceptance would return a differently scaled value, or would switch the select pins during the frame. Other reads keep requesting while busy, or hold the request high across the hold window, which exposes a design that restarts early or shortens the sample-high interval.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    localparam int RSV_WORD_W = 16;

    typedef enum logic {
        CH_ANGLE = 1'b0,
        CH_VEL   = 1'b1
    } rsv_chan_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_XFER,
        ST_HOLD
    } rsv_state_e;

    typedef struct packed {
        rsv_chan_e  chan;
        logic [1:0] res;
        logic       hyst;
    } rsv_cfg_t;

    // {A1, A0}: angle register 00, velocity register 10
    function automatic logic [1:0] mode_pins(rsv_chan_e ch);
        return {ch == CH_VEL, 1'b0};
    endfunction

endpackage

// File: rtl/rsv_spi_rx.sv
module rsv_spi_rx
    import rsv_pkg::*;
#(
    parameter int SCK_HALF = 2,
    parameter int NBITS    = RSV_WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             miso_i,
    output logic             sck_o,
    output logic             cs_n_o,
    output logic [NBITS-1:0] word_o,
    output logic             fin_o
);
    localparam int HCW    = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam int NHALF  = 2 * NBITS;
    localparam int PW     = $clog2(NHALF);

    logic           active;
    logic [HCW-1:0] hcnt;
    logic [PW-1:0]  phase;
    logic           half_end;
    logic           last_phase;

    assign half_end   = (hcnt == HCW'(SCK_HALF - 1));
    assign last_phase = (phase == PW'(NHALF - 1));
    assign fin_o      = active && half_end && last_phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cs_n_o <= 1'b1;
            sck_o  <= 1'b1;
            hcnt   <= '0;
            phase  <= '0;
            word_o <= '0;
        end else if (!active) begin
            if (start_i) begin
                active <= 1'b1;
                cs_n_o <= 1'b0;
                sck_o  <= 1'b0;
                hcnt   <= '0;
                phase  <= '0;
            end
        end else if (half_end) begin
            hcnt <= '0;
            if (last_phase) begin
                active <= 1'b0;
                cs_n_o <= 1'b1;
                sck_o  <= 1'b1;
            end else begin
                phase <= phase + 1'b1;
                sck_o <= ~sck_o;
                if (!sck_o) begin
                    word_o <= {word_o[NBITS-2:0], miso_i};
                end
            end
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

endmodule

// File: rtl/rsv_seq.sv
module rsv_seq
    import rsv_pkg::*;
#(
    parameter int SETUP_CYC = 8,
    parameter int HOLD_CYC  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_i,
    input  rsv_cfg_t   cfg_i,
    input  logic       fin_i,
    output logic       busy_o,
    output logic       sample_n_o,
    output logic [1:0] mode_o,
    output rsv_cfg_t   cfg_q_o,
    output logic       start_o
);
    localparam int MAXW = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int CW   = $clog2(MAXW + 1);

    rsv_state_e    st;
    logic [CW-1:0] cnt;

    assign busy_o  = (st != ST_IDLE);
    assign start_o = (st == ST_SETUP) && (cnt == CW'(SETUP_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            sample_n_o <= 1'b1;
            mode_o     <= 2'b00;
            cfg_q_o    <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (req_i) begin
                        st         <= ST_SETUP;
                        cnt        <= '0;
                        sample_n_o <= 1'b0;
                        cfg_q_o    <= cfg_i;
                        mode_o     <= mode_pins(cfg_i.chan);
                    end
                end
                ST_SETUP: begin
                    if (start_o) begin
                        st  <= ST_XFER;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_XFER: begin
                    if (fin_i) begin
                        st         <= ST_HOLD;
                        sample_n_o <= 1'b1;
                        cnt        <= '0;
                    end
                end
                ST_HOLD: begin
                    if (cnt == CW'(HOLD_CYC - 1)) begin
                        st <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rsv_fmt.sv
module rsv_fmt
    import rsv_pkg::*;
(
    input  logic [RSV_WORD_W-1:0] word_i,
    input  rsv_cfg_t              cfg_i,
    output logic [RSV_WORD_W-1:0] value_o
);
    localparam int NRES = 4;

    logic signed [RSV_WORD_W-1:0] sword;
    logic [RSV_WORD_W-1:0] vel_c [NRES];
    logic [RSV_WORD_W-1:0] ang_c [NRES];

    assign sword = word_i;

    // one justification variant per resolution code: 10, 12, 14, 16 bits
    for (genvar g = 0; g < NRES; g++) begin : g_res
        localparam int SH = RSV_WORD_W - (10 + 2 * g);
        assign vel_c[g] = sword >>> SH;
        assign ang_c[g] = word_i >> SH;
    end

    always_comb begin
        if (cfg_i.chan == CH_VEL) begin
            value_o = vel_c[cfg_i.res];
        end else if (cfg_i.hyst) begin
            value_o = ang_c[cfg_i.res];
        end else begin
            value_o = word_i;
        end
    end

endmodule

// File: rtl/rsv_sample_reader.sv
module rsv_sample_reader
    import rsv_pkg::*;
#(
    parameter int SETUP_CYC = 8,
    parameter int HOLD_CYC  = 3,
    parameter int SCK_HALF  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_i,
    input  logic        chan_i,
    input  logic [1:0]  res_code_i,
    input  logic        hyst_en_i,
    output logic        busy_o,
    output logic        sample_n_o,
    output logic [1:0]  mode_o,
    output logic        spi_sck_o,
    output logic        spi_cs_n_o,
    input  logic        spi_miso_i,
    output logic [15:0] value_o,
    output logic        valid_o
);
    rsv_cfg_t               cfg_in;
    rsv_cfg_t               cfg_q;
    logic                   start;
    logic                   fin;
    logic [RSV_WORD_W-1:0]  raw_word;
    logic [RSV_WORD_W-1:0]  scaled;

    assign cfg_in = '{chan: rsv_chan_e'(chan_i), res: res_code_i, hyst: hyst_en_i};

    rsv_seq #(
        .SETUP_CYC (SETUP_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req_i),
        .cfg_i      (cfg_in),
        .fin_i      (fin),
        .busy_o     (busy_o),
        .sample_n_o (sample_n_o),
        .mode_o     (mode_o),
        .cfg_q_o    (cfg_q),
        .start_o    (start)
    );

    rsv_spi_rx #(
        .SCK_HALF (SCK_HALF),
        .NBITS    (RSV_WORD_W)
    ) u_spi (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .miso_i  (spi_miso_i),
        .sck_o   (spi_sck_o),
        .cs_n_o  (spi_cs_n_o),
        .word_o  (raw_word),
        .fin_o   (fin)
    );

    rsv_fmt u_fmt (
        .word_i  (raw_word),
        .cfg_i   (cfg_q),
        .value_o (scaled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            value_o <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= fin;
            if (fin) begin
                value_o <= scaled;
            end
        end
    end

endmodule

// File: rtl/rsv_sample_reader_chk.sv
module rsv_sample_reader_chk #(
    parameter int SETUP_CYC = 8,
    parameter int HOLD_CYC  = 3
) (
    input logic        clk,
    input logic        rst,
    input logic        busy_o,
    input logic        sample_n_o,
    input logic        spi_sck_o,
    input logic        spi_cs_n_o,
    input logic [15:0] value_o,
    input logic        valid_o
);
    logic [15:0] low_cnt;
    logic [15:0] high_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= '0;
            high_cnt <= 16'hFFFF;
        end else begin
            if (sample_n_o)
                low_cnt <= '0;
            else if (spi_cs_n_o && low_cnt != 16'hFFFF)
                low_cnt <= low_cnt + 1'b1;
            if (!sample_n_o)
                high_cnt <= '0;
            else if (high_cnt != 16'hFFFF)
                high_cnt <= high_cnt + 1'b1;
        end
    end

    // R7
    valid_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R7
    value_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(value_o));

    // R7
    valid_pins_idle_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (sample_n_o && spi_cs_n_o && busy_o));

    // R2
    accept_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sample_n_o) |-> !$past(busy_o));

    // R2
    setup_window_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n_o) |-> (low_cnt == 16'(SETUP_CYC)));

    // R4
    frame_in_sample_chk: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n_o |-> !sample_n_o);

    // R4
    sck_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n_o |-> spi_sck_o);

    // R8
    hold_window_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sample_n_o) |-> (high_cnt >= 16'(HOLD_CYC)));

endmodule

bind rsv_sample_reader rsv_sample_reader_chk #(
    .SETUP_CYC (SETUP_CYC),
    .HOLD_CYC  (HOLD_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy_o     (busy_o),
    .sample_n_o (sample_n_o),
    .spi_sck_o  (spi_sck_o),
    .spi_cs_n_o (spi_cs_n_o),
    .value_o    (value_o),
    .valid_o    (valid_o)
);

// File: tb/sim_rsv_sample_reader.sv
module sim_rsv_sample_reader;
    localparam int S     = 8;
    localparam int HD    = 3;
    localparam int HF    = 2;
    localparam int FRAME = 32 * HF;
    localparam int LASTK = S + FRAME + HD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0;
    logic        chan_i = 1'b0;
    logic [1:0]  res_code_i = 2'd0;
    logic        hyst_en_i = 1'b0;
    logic        busy_o, sample_n_o, spi_sck_o, spi_cs_n_o, valid_o;
    logic [1:0]  mode_o;
    logic        spi_miso_i = 1'b0;
    logic [15:0] value_o;

    always #5 clk = ~clk;

    rsv_sample_reader #(.SETUP_CYC(S), .HOLD_CYC(HD), .SCK_HALF(HF)) u0 (
        .clk(clk), .rst(rst), .req_i(req_i), .chan_i(chan_i),
        .res_code_i(res_code_i), .hyst_en_i(hyst_en_i), .busy_o(busy_o),
        .sample_n_o(sample_n_o), .mode_o(mode_o), .spi_sck_o(spi_sck_o),
        .spi_cs_n_o(spi_cs_n_o), .spi_miso_i(spi_miso_i),
        .value_o(value_o), .valid_o(valid_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] expect_val(input logic [15:0] w, input logic ch,
                                               input logic [1:0] rc, input logic hy);
        int res = 10 + 2 * int'(rc);
        int sh  = 16 - res;
        int v;
        if (ch) begin
            v = int'(w) >> sh;
            if ((v & (1 << (res - 1))) != 0)
                v = v | (32'h0000FFFF ^ ((1 << res) - 1));
            return v[15:0];
        end else if (hy) begin
            return w >> sh;
        end
        return w;
    endfunction

    // converter model: shifts out one bit per falling SCK edge, MSB first
    logic [15:0] tx_word = 16'h0;
    int   sidx = 0;
    logic prev_cs = 1'b1;
    logic prev_sck = 1'b1;
    always @(negedge clk) begin
        if (spi_cs_n_o) begin
            sidx = 0;
        end else if (prev_cs || (prev_sck && !spi_sck_o)) begin
            if (sidx < 16) spi_miso_i <= tx_word[15 - sidx];
            sidx = sidx + 1;
        end
        prev_cs  <= spi_cs_n_o;
        prev_sck <= spi_sck_o;
    end

    // cycle-by-cycle reference timeline
    int          mk = 0;
    logic        mchan = 1'b0;
    logic [15:0] mexp = 16'h0;
    logic [15:0] mlast = 16'h0;
    always @(posedge clk) begin
        if (rst) begin
            mk    <= 0;
            mchan <= 1'b0;
            mlast <= 16'h0;
        end else if (mk == 0) begin
            if (req_i) begin
                mk    <= 1;
                mchan <= chan_i;
                mexp  <= expect_val(tx_word, chan_i, res_code_i, hyst_en_i);
            end
        end else begin
            if (mk == S + FRAME) mlast <= mexp;
            mk <= (mk == LASTK) ? 0 : mk + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic e_samp, e_cs, e_sck, e_busy, e_valid;
            e_busy  = (mk != 0);
            e_samp  = !(mk >= 1 && mk <= S + FRAME);
            e_cs    = !(mk >= S + 1 && mk <= S + FRAME);
            e_sck   = e_cs ? 1'b1 : (((mk - S - 1) / HF) % 2 == 1);
            e_valid = (mk == S + FRAME + 1);
            check(sample_n_o == e_samp, "R2 sample strobe", sample_n_o, e_samp);
            check(spi_cs_n_o == e_cs, "R4 chip select", spi_cs_n_o, e_cs);
            check(spi_sck_o == e_sck, "R4 serial clock", spi_sck_o, e_sck);
            check(busy_o == e_busy, "R8 busy window", busy_o, e_busy);
            check(valid_o == e_valid, "R7 valid strobe", valid_o, e_valid);
            check(value_o == mlast, "R7 value register", value_o, mlast);
            check(mode_o == {mchan, 1'b0}, "R3 select pins", mode_o, {mchan, 1'b0});
        end
    end

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    task automatic do_read(input logic ch, input logic [1:0] rc, input logic hy,
                           input logic [15:0] w, input bit mid_change, input bit poke);
        logic [15:0] ev;
        wait_idle();
        tx_word    = w;
        chan_i     = ch;
        res_code_i = rc;
        hyst_en_i  = hy;
        req_i      = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        ev = expect_val(w, ch, rc, hy);
        if (mid_change) begin
            repeat (12) @(negedge clk);
            chan_i     = ~ch;
            res_code_i = ~rc;
            hyst_en_i  = ~hy;
        end
        if (poke) begin
            repeat (5) @(negedge clk);
            req_i = 1'b1;
            repeat (20) @(negedge clk);
            req_i = 1'b0;
        end
        wait_idle();
        if (mid_change)
            check(value_o == ev, "R9 captured settings", value_o, ev);
        else if (ch)
            check(value_o == ev, "R5 velocity result", value_o, ev);
        else
            check(value_o == ev, "R6 angle result", value_o, ev);
    endtask

    initial begin
        logic [15:0] words [6];
        words[0] = 16'h8001; words[1] = 16'h7FFF; words[2] = 16'hFFFF;
        words[3] = 16'hA5C3; words[4] = 16'h0040; words[5] = 16'h2BD6;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(sample_n_o == 1'b1, "R1 sample idle", sample_n_o, 1);
        check(spi_cs_n_o == 1'b1, "R1 cs idle", spi_cs_n_o, 1);
        check(spi_sck_o == 1'b1, "R1 sck idle", spi_sck_o, 1);
        check(busy_o == 1'b0 && valid_o == 1'b0, "R1 busy valid", {busy_o, valid_o}, 0);
        check(value_o == 16'h0 && mode_o == 2'b00, "R1 value mode", {value_o, mode_o}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        for (int rc = 0; rc < 4; rc++) begin
            for (int ch = 0; ch < 2; ch++) begin
                for (int hy = 0; hy < 2; hy++) begin
                    do_read(ch[0], rc[1:0], hy[0], words[(rc * 4 + ch * 2 + hy) % 6], 1'b0, 1'b0);
                end
            end
        end
        do_read(1'b1, 2'd0, 1'b1, 16'h8020, 1'b1, 1'b0);
        do_read(1'b0, 2'd1, 1'b1, 16'hF0F0, 1'b1, 1'b0);
        do_read(1'b1, 2'd2, 1'b0, 16'h9004, 1'b0, 1'b1);
        do_read(1'b0, 2'd3, 1'b0, 16'h1234, 1'b0, 1'b1);
        // R8 request held high across the hold window: back-to-back reads
        wait_idle();
        tx_word = 16'hC001; chan_i = 1'b1; res_code_i = 2'd1; hyst_en_i = 1'b1;
        req_i = 1'b1;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        while (!busy_o) @(negedge clk);
        req_i = 1'b0;
        wait_idle();
        check(value_o == expect_val(16'hC001, 1'b1, 2'd1, 1'b1), "R8 back-to-back result",
              value_o, expect_val(16'hC001, 1'b1, 2'd1, 1'b1));
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog expired actual=busy expected=idle");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule